// File: doc/BRIEF.md
# Block Memory Copy Engine

A sequential engine that moves bytes from one region of a byte-wide memory to another. A caller supplies a source pointer, a destination pointer, a 16-bit byte count, a direction (ascending or descending), a repeat flag and an 8-bit status flag byte, then pulses start. For each byte the engine reads the location at the source pointer and writes that byte to the location at the destination pointer. It then steps both pointers by one in the chosen direction and lowers the count by one.

In single-step mode one byte is moved per start. In repeat mode the engine keeps moving bytes until the count reaches zero. The count is tested only after a byte has moved, so a starting count of zero wraps and covers the whole 65536-byte space. When the run ends the engine presents the updated pointers, the count and the flag byte, and pulses done. In the flag byte, bit 2 reports whether the count is still nonzero, bits 4 and 1 are cleared, and the other bits pass through.

Top module: `blk_copy_engine`

## Requirements
- R1: Each byte moved is read from the address held in the source pointer, and the same byte is then written to the address held in the destination pointer. The sequential copy semantics hold even when the two regions overlap.
- R2: In ascending mode (dir_down_i=0) both pointers increase by 1 after each byte. In descending mode (dir_down_i=1) both decrease by 1. Both wrap modulo 65536.
- R3: The count decreases by 1 after every byte and wraps modulo 65536, so a count of 0 becomes 16'hFFFF after one byte.
- R4: After each byte, flag bit 2 is 1 when the updated count is nonzero and 0 when it is zero.
- R5: After each byte, flag bits 4 and 1 are 0, and bits 7, 6, 5, 3 and 0 keep the values given on flags_i at start.
- R6: With repeat_i=0, exactly one byte is moved whatever the count. done_o is high for exactly one cycle and ready_o is then high.
- R7: With repeat_i=1, bytes are moved until the count reaches zero: a start count N of 1 or more moves N bytes, and a start count of 0 moves 65536 bytes.
- R8: The read strobe is high in the cycle after start is accepted, and the matching write strobe is high in the next cycle, so each byte takes two cycles. done_o rises in the cycle after the last write.
- R9: ready_o is low while a copy runs, and start_i is ignored during that time: inputs presented then change neither the run nor its results.
- R10: After reset, ready_o is 1, done_o, mem_rd_o and mem_wr_o are 0, and the pointer, count and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a copy; accepted only while ready_o is high |
| dir_down_i | input | 1 | 1 = pointers decrease, 0 = pointers increase |
| repeat_i | input | 1 | 1 = run until the count reaches zero, 0 = one byte |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| cnt_i | input | 16 | Initial byte count |
| flags_i | input | 8 | Incoming flag byte |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe; data returns on mem_rdata_i one cycle later |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| ready_o | output | 1 | Idle, able to accept start |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| src_o | output | 16 | Current source pointer |
| dst_o | output | 16 | Current destination pointer |
| cnt_o | output | 16 | Current count |
| flags_o | output | 8 | Current flag byte |

## Verification
Counting from the clock edge that samples start, the first read strobe is due one cycle later. Each write follows its read by one cycle, and done is due 2N+1 cycles after that edge for an N-byte run. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge, requires done at exactly edge 2N+1, and requires done to be low again one edge later. Pointer, count and flag results are compared once done is seen, and memory contents are compared with a byte-by-byte sequential model. The per-byte pointer, count and flag updates are also checked by properties one cycle after every write strobe.

// File: rtl/bce_pkg.sv
package bce_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} bce_state_e;

  localparam int FLG_W  = 8;
  localparam int FLG_PV = 2;
  localparam int FLG_H  = 4;
  localparam int FLG_N  = 1;

  function automatic logic [FLG_W-1:0] step_flags(input logic [FLG_W-1:0] f, input logic more);
    logic [FLG_W-1:0] r;
    r         = f;
    r[FLG_H]  = 1'b0;
    r[FLG_N]  = 1'b0;
    r[FLG_PV] = more;
    return r;
  endfunction
endpackage

// File: rtl/bce_step_reg.sv
module bce_step_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] init_i,
  input  logic         step_i,
  input  logic         down_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= init_i;
    else if (step_i) q <= down_i ? q - ONE : q + ONE;
  end

  assign q_o = q;
endmodule

// File: rtl/bce_flag_reg.sv
module bce_flag_reg
  import bce_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [FLG_W-1:0] init_i,
  input  logic             step_i,
  input  logic             more_i,
  output logic [FLG_W-1:0] flags_o
);
  logic [FLG_W-1:0] f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     f <= '0;
    else if (load_i) f <= init_i;
    else if (step_i) f <= step_flags(f, more_i);
  end

  assign flags_o = f;
endmodule

// File: rtl/bce_fsm.sv
module bce_fsm
  import bce_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       repeat_i,
  input  logic       dir_down_i,
  input  logic       last_i,
  output bce_state_e state_o,
  output logic       load_o,
  output logic       step_o,
  output logic       down_o,
  output logic       done_o
);
  bce_state_e st, st_nx;
  logic rep_q, down_q, done_q;

  assign load_o = (st == ST_IDLE) && start_i;
  assign step_o = (st == ST_WR);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start_i) st_nx = ST_RD;
      ST_RD:   st_nx = ST_WR;
      ST_WR:   st_nx = (rep_q && !last_i) ? ST_RD : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= ST_IDLE;
      rep_q  <= 1'b0;
      down_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= (st == ST_WR) && (st_nx == ST_IDLE);
      if (load_o) begin
        rep_q  <= repeat_i;
        down_q <= dir_down_i;
      end
    end
  end

  assign state_o = st;
  assign down_o  = down_q;
  assign done_o  = done_q;
endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
  import bce_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dir_down_i,
  input  logic             repeat_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [AW-1:0]    cnt_i,
  input  logic [FLG_W-1:0] flags_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             ready_o,
  output logic             done_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [AW-1:0]    cnt_o,
  output logic [FLG_W-1:0] flags_o
);
  localparam int NPTR = 2;
  localparam logic [AW-1:0] CNT_ONE = AW'(1);

  bce_state_e state;
  logic load, step, down, last;
  logic [AW-1:0] ptr_init [NPTR];
  logic [AW-1:0] ptr_q    [NPTR];

  // last byte of the run: count reaches zero after this step
  assign last = (cnt_o == CNT_ONE);

  bce_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .repeat_i   (repeat_i),
    .dir_down_i (dir_down_i),
    .last_i     (last),
    .state_o    (state),
    .load_o     (load),
    .step_o     (step),
    .down_o     (down),
    .done_o     (done_o)
  );

  assign ptr_init[0] = src_i;
  assign ptr_init[1] = dst_i;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    bce_step_reg #(.W(AW)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .init_i (ptr_init[g]),
      .step_i (step),
      .down_i (down),
      .q_o    (ptr_q[g])
    );
  end

  bce_step_reg #(.W(AW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .init_i (cnt_i),
    .step_i (step),
    .down_i (1'b1),
    .q_o    (cnt_o)
  );

  bce_flag_reg u_flg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .init_i  (flags_i),
    .step_i  (step),
    .more_i  (!last),
    .flags_o (flags_o)
  );

  assign src_o       = ptr_q[0];
  assign dst_o       = ptr_q[1];
  assign ready_o     = (state == ST_IDLE);
  assign mem_rd_o    = (state == ST_RD);
  assign mem_wr_o    = (state == ST_WR);
  assign mem_addr_o  = (state == ST_WR) ? ptr_q[1] : ptr_q[0];
  assign mem_wdata_o = mem_rdata_i;
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          ready_o,
  input logic          done_o,
  input logic [AW-1:0] src_o,
  input logic [AW-1:0] dst_o,
  input logic [AW-1:0] cnt_o,
  input logic [7:0]    flags_o
);
  AST_RD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (mem_addr_o == src_o && !mem_wr_o)); // R1
  AST_WR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o == dst_o)); // R1
  AST_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> mem_wr_o); // R8
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> ((AW'(src_o - $past(src_o)) == AW'(dst_o - $past(dst_o))) &&
                  ((AW'(src_o - $past(src_o)) == AW'(1)) || (AW'(src_o - $past(src_o)) == {AW{1'b1}})))); // R2
  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (cnt_o == AW'($past(cnt_o) - AW'(1)))); // R3
  AST_PV_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (flags_o[2] == (cnt_o != '0))); // R4
  AST_HN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (!flags_o[4] && !flags_o[1])); // R5
  AST_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> ({flags_o[7:5], flags_o[3], flags_o[0]} ==
                  {$past(flags_o[7:5]), $past(flags_o[3]), $past(flags_o[0])})); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ready_o && $past(mem_wr_o))); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> ($stable(src_o) && $stable(dst_o) && $stable(cnt_o) && $stable(flags_o))); // R9
  AST_START_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> (mem_rd_o && !ready_o)); // R8
endmodule

bind blk_copy_engine bce_checker #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .src_o      (src_o),
  .dst_o      (dst_o),
  .cnt_o      (cnt_o),
  .flags_o    (flags_o)
);

// File: tb/blk_copy_engine_tb.sv
`timescale 1ns/1ps
module blk_copy_engine_tb;
  localparam int MW = 10;
  localparam int MSZ = 1 << MW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dn = 1'b0, rep = 1'b0;
  logic [15:0] src = '0, dst = '0, cnt = '0;
  logic [7:0] flg = '0;
  logic [15:0] maddr, src_o, dst_o, cnt_o;
  logic mrd, mwr, ready, done;
  logic [7:0] wdata, rdata, flags_o;
  logic [7:0] mem [MSZ];
  logic [7:0] shd [MSZ];
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  blk_copy_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_down_i(dn), .repeat_i(rep),
    .src_i(src), .dst_i(dst), .cnt_i(cnt), .flags_i(flg),
    .mem_addr_o(maddr), .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .ready_o(ready), .done_o(done),
    .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .flags_o(flags_o)
  );

  function automatic logic [7:0] init_byte(input int i);
    return 8'(i * 7 + 13) ^ 8'(i >> 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MSZ; i++) mem[i] <= init_byte(i);
      rdata <= '0;
    end else begin
      if (mwr) mem[maddr[MW-1:0]] <= wdata;
      if (mrd) rdata <= mem[maddr[MW-1:0]];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act cycles=%0d exp below 190000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_flags(input logic [7:0] f, input logic [15:0] c);
    return {f[7:5], 1'b0, f[3], c != 16'd0, 1'b0, f[0]};
  endfunction

  task automatic run_op(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                        input bit down, input bit rp, input logic [7:0] f, input bit poke);
    int n, k, wrs, bad;
    logic [15:0] es, ed, ec;
    n = rp ? ((c == 16'd0) ? 65536 : int'(c)) : 1;
    es = s; ed = d; ec = c;
    for (int i = 0; i < n; i++) begin
      shd[ed[MW-1:0]] = shd[es[MW-1:0]];
      es = down ? es - 16'd1 : es + 16'd1;
      ed = down ? ed - 16'd1 : ed + 16'd1;
      ec = ec - 16'd1;
    end
    @(negedge clk);
    src = s; dst = d; cnt = c; dn = down; rep = rp; flg = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mrd && !ready && !mwr, "R8 read strobe after start", {mrd, ready, mwr}, 3'b100);
    k = 1; wrs = 0;
    while (!done && k < 140000) begin
      if (mwr) wrs++;
      if (poke && k == 2) begin
        start = 1'b1; src = ~s; dst = ~d; cnt = 16'd3; dn = ~down; rep = ~rp; flg = ~f;
      end else start = 1'b0;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(done && k == 2 * n + 1, "R8 done timing", k, 2 * n + 1);
    chk(wrs == n, rp ? "R7 bytes moved" : "R6 single byte", wrs, n);
    chk(src_o == es && dst_o == ed, "R2 pointers", {src_o, dst_o}, {es, ed});
    chk(cnt_o == ec, "R3 count", cnt_o, ec);
    chk(flags_o[2] == (ec != 0), "R4 pv flag", flags_o, exp_flags(f, ec));
    chk(flags_o == exp_flags(f, ec), "R5 flag byte", flags_o, exp_flags(f, ec));
    if (poke) chk(ready && src_o == es && cnt_o == ec, "R9 start ignored while busy", src_o, es);
    @(negedge clk);
    chk(!done && ready, "R6 done one cycle", {done, ready}, 2'b01);
    bad = 0;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== shd[i]) bad++;
    chk(bad == 0, "R1 memory contents", bad, 0);
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) shd[i] = init_byte(i);
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(ready && !done && !mrd && !mwr, "R10 reset idle", {ready, done, mrd, mwr}, 4'b1000);
    chk(src_o == 0 && dst_o == 0 && cnt_o == 0 && flags_o == 0, "R10 reset values",
        {src_o, cnt_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !mrd && !mwr, "R10 idle after reset", {ready, mrd, mwr}, 3'b100);
    run_op(16'h0010, 16'h0200, 16'd5, 1'b0, 1'b0, 8'hFF, 1'b0);
    run_op(16'h0020, 16'h0120, 16'd1, 1'b1, 1'b0, 8'h00, 1'b0);
    run_op(16'h0030, 16'h0130, 16'd0, 1'b0, 1'b0, 8'h29, 1'b0);
    run_op(16'h0040, 16'h0300, 16'd8, 1'b0, 1'b1, 8'hD7, 1'b1);
    run_op(16'h0003, 16'h0105, 16'd6, 1'b1, 1'b1, 8'h5A, 1'b0);
    run_op(16'hFFFE, 16'h0280, 16'd4, 1'b0, 1'b1, 8'hA5, 1'b0);
    run_op(16'h0050, 16'h0052, 16'd5, 1'b0, 1'b1, 8'h3C, 1'b0);
    run_op(16'h0060, 16'h0360, 16'd1, 1'b0, 1'b1, 8'h80, 1'b1);
    for (int t = 0; t < 16; t++) begin
      run_op(16'($urandom), 16'($urandom), 16'($urandom_range(1, 20)),
             1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    end
    run_op(16'h0100, 16'h0180, 16'd0, 1'b0, 1'b1, 8'h6B, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule